// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timer channels and the interrupt fabric of a chip. Each channel raises a one-cycle expiry pulse. The router then delivers that event in one of three ways, chosen by the channel's configuration:

- as a level interrupt, held on an output line;
- as a one-cycle edge pulse on an output line;
- as a 32-bit message write to memory.

The router also holds the per-channel interrupt status register, which software clears by writing ones.

A compatibility mode fixes channel 0 and channel 1 to two dedicated lines, whatever their route fields say. The same mode takes the real-time-clock interrupt line away from its external source. While the mode is off, the external real-time-clock interrupt passes straight through to its line.

Each channel has its own routing and delivery configuration. When several channels request a message write in the same cycle, the writes leave one per cycle, lowest channel index first.

Top module: `tmr_irq_router`

## Requirements
- R1: After reset the status register reads 0, every interrupt line is low and no message write is requested.
- R2: An event on an enabled channel with message delivery off and level type (type bit 1) sets its status bit on the next clock edge. The line chosen by the channel's 5-bit route field then stays high until the status bit is cleared.
- R3: An event on an enabled channel with message delivery off and edge type (type bit 0) clears its status bit. It also drives the routed line high for exactly the one cycle after the event edge.
- R4: A status write clears each bit that is 1 in both the write data and the status register, and that channel's line drops. Bits written as 0 keep their value.
- R5: An event that arrives while the channel enable or the global enable is 0 clears the channel's status bit and leaves its line low.
- R6: With message delivery on, an event produces a one-cycle write request in the cycle after the event edge. The write address is bits 63:32 of the channel's 64-bit message word and the write data is bits 31:0. The status bit and the routed line are untouched.
- R7: When a channel's message enable goes from 0 to 1, any level interrupt it has pending is withdrawn. Its line drops at once and its status bit is clear after the next edge.
- R8: In compatibility mode, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields say. All other channels keep using their route fields. A route value of 24 or more reaches no line.
- R9: With compatibility mode off, line 8 follows the external real-time-clock input. Entering the mode removes that input from line 8, and leaving the mode brings back its current level.
- R10: Message requests from several channels in the same cycle are sent one per cycle, lowest channel index first, and none is lost.
- R11: If an event sets a status bit in the same cycle that a status write clears it, the event wins and the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fire_i | input | N_TMR | Per-channel expiry pulse |
| tmr_en_i | input | N_TMR | Per-channel interrupt enable |
| lvl_type_i | input | N_TMR | 1 = level type, 0 = edge type |
| msg_en_i | input | N_TMR | Per-channel message delivery enable |
| route_i | input | N_TMR*RTW | Per-channel line index, channel i at bits [i*RTW +: RTW] |
| msg_word_i | input | N_TMR*64 | Per-channel message word: address in [63:32], data in [31:0] |
| glb_en_i | input | 1 | Global enable |
| legacy_i | input | 1 | Compatibility mode |
| rtc_irq_i | input | 1 | External real-time-clock interrupt |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | N_TMR | Status write data, 1 clears |
| irq_o | output | N_LINES | Interrupt lines |
| msg_req_o | output | 1 | Message write request |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |
| sts_o | output | N_TMR | Interrupt status register |

## Verification
The stimulus fires each channel in every delivery kind it supports: level, edge, message and disabled. This separates a held line from a one-cycle pulse, and a status set from a status clear.

Two channels are fired together with message delivery on. This tells correct ordering apart from dropped or duplicated writes.

The same channels are fired again in compatibility mode. This distinguishes the fixed lines from the route fields, and the real-time-clock pass-through from its suppression.

Finally, an event collides with a status write on the same bit and in the same cycle, to separate the set-wins priority from the clear-wins priority.

// File: rtl/tmr_irq_router.sv
module tmr_irq_router #(
  parameter int N_TMR       = 4,
  parameter int N_LINES     = 24,
  parameter int RTW         = 5,
  parameter int LEG_T0_LINE = 0,
  parameter int LEG_T1_LINE = 8,
  parameter int RTC_LINE    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_TMR-1:0]       fire_i,
  input  logic [N_TMR-1:0]       tmr_en_i,
  input  logic [N_TMR-1:0]       lvl_type_i,
  input  logic [N_TMR-1:0]       msg_en_i,
  input  logic [N_TMR*RTW-1:0]   route_i,
  input  logic [N_TMR*64-1:0]    msg_word_i,
  input  logic                   glb_en_i,
  input  logic                   legacy_i,
  input  logic                   rtc_irq_i,
  input  logic                   sts_wr_i,
  input  logic [N_TMR-1:0]       sts_wdata_i,
  output logic [N_LINES-1:0]     irq_o,
  output logic                   msg_req_o,
  output logic [31:0]            msg_addr_o,
  output logic [31:0]            msg_data_o,
  output logic [N_TMR-1:0]       sts_o
);

  localparam int MW = 64;

  logic [N_TMR-1:0] sts_q, pulse_q, pend_q, msg_en_q;
  logic [N_TMR-1:0] en_ok, ev_off, ev_msg, ev_lvl, ev_edge;
  logic [N_TMR-1:0] wclr, msg_rise, cand, grant;
  logic [31:0]      sel_addr, sel_data;
  logic [N_LINES-1:0] irq_c;

  assign en_ok    = tmr_en_i & {N_TMR{glb_en_i}};
  assign ev_off   = fire_i & ~en_ok;
  assign ev_msg   = fire_i & en_ok & msg_en_i;
  assign ev_lvl   = fire_i & en_ok & ~msg_en_i & lvl_type_i;
  assign ev_edge  = fire_i & en_ok & ~msg_en_i & ~lvl_type_i;
  assign wclr     = sts_wr_i ? (sts_wdata_i & sts_q) : '0;
  assign msg_rise = msg_en_i & ~msg_en_q;
  assign cand     = pend_q | ev_msg;
  assign grant    = cand & (~cand + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q    <= '0;
      pulse_q  <= '0;
      pend_q   <= '0;
      msg_en_q <= '0;
    end else begin
      sts_q    <= (sts_q & ~wclr & ~msg_rise & ~ev_off & ~ev_edge) | ev_lvl;
      pulse_q  <= ev_edge;
      pend_q   <= cand & ~grant;
      msg_en_q <= msg_en_i;
    end
  end

  always_comb begin
    sel_addr = '0;
    sel_data = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (grant[i]) begin
        sel_addr = msg_word_i[i*MW+32 +: 32];
        sel_data = msg_word_i[i*MW +: 32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_req_o  <= 1'b0;
      msg_addr_o <= '0;
      msg_data_o <= '0;
    end else begin
      msg_req_o  <= |cand;
      msg_addr_o <= sel_addr;
      msg_data_o <= sel_data;
    end
  end

  function automatic int eff_route(int idx, logic leg, logic [RTW-1:0] rf);
    if (leg && idx == 0) return LEG_T0_LINE;
    if (leg && idx == 1) return LEG_T1_LINE;
    return int'(rf);
  endfunction

  always_comb begin
    irq_c = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if ((sts_q[i] & ~msg_en_i[i]) | pulse_q[i]) begin
        for (int l = 0; l < N_LINES; l++) begin
          if (eff_route(i, legacy_i, route_i[i*RTW +: RTW]) == l) irq_c[l] = 1'b1;
        end
      end
    end
    if (!legacy_i && rtc_irq_i) irq_c[RTC_LINE] = 1'b1;
  end

  assign irq_o = irq_c;
  assign sts_o = sts_q;

endmodule

// File: rtl/tmr_irq_router_chk.sv
module tmr_irq_router_chk #(
  parameter int N_TMR       = 4,
  parameter int N_LINES     = 24,
  parameter int LEG_T0_LINE = 0,
  parameter int RTC_LINE    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_TMR-1:0]   fire_i,
  input logic [N_TMR-1:0]   tmr_en_i,
  input logic [N_TMR-1:0]   lvl_type_i,
  input logic [N_TMR-1:0]   msg_en_i,
  input logic               glb_en_i,
  input logic               legacy_i,
  input logic               rtc_irq_i,
  input logic               sts_wr_i,
  input logic [N_TMR-1:0]   sts_wdata_i,
  input logic [N_LINES-1:0] irq_o,
  input logic [N_TMR-1:0]   sts_o
);

  for (genvar i = 0; i < N_TMR; i++) begin : g_ch
    // R2
    lvl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i[i] && tmr_en_i[i] && glb_en_i && !msg_en_i[i] && lvl_type_i[i] |=> sts_o[i]);
    // R3
    edge_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i[i] && tmr_en_i[i] && glb_en_i && !msg_en_i[i] && !lvl_type_i[i] |=> !sts_o[i]);
    // R5
    off_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i[i] && !(tmr_en_i[i] && glb_en_i) |=> !sts_o[i]);
    // R4
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts_wr_i && sts_wdata_i[i] && sts_o[i] && !fire_i[i] |=> !sts_o[i]);
    // R4
    w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts_wr_i && !sts_wdata_i[i] && sts_o[i] && !fire_i[i] && !msg_en_i[i] |=> sts_o[i]);
  end

  // R9
  rtc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy_i && rtc_irq_i |-> irq_o[RTC_LINE]);
  // R8
  leg_t0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_i && sts_o[0] && !msg_en_i[0] |-> irq_o[LEG_T0_LINE]);

endmodule

bind tmr_irq_router tmr_irq_router_chk #(
  .N_TMR(N_TMR), .N_LINES(N_LINES), .LEG_T0_LINE(LEG_T0_LINE), .RTC_LINE(RTC_LINE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fire_i(fire_i), .tmr_en_i(tmr_en_i),
  .lvl_type_i(lvl_type_i), .msg_en_i(msg_en_i), .glb_en_i(glb_en_i),
  .legacy_i(legacy_i), .rtc_irq_i(rtc_irq_i), .sts_wr_i(sts_wr_i),
  .sts_wdata_i(sts_wdata_i), .irq_o(irq_o), .sts_o(sts_o)
);

// File: tb/tmr_irq_router_tb_top.sv
module tmr_irq_router_tb_top;
  localparam int N = 4;
  localparam int L = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] fire_i = '0, tmr_en_i = '0, lvl_type_i = '0, msg_en_i = '0, sts_wdata_i = '0;
  logic [N*5-1:0] route_i = '0;
  logic [N*64-1:0] msg_word_i = '0;
  logic glb_en_i = 1'b0, legacy_i = 1'b0, rtc_irq_i = 1'b0, sts_wr_i = 1'b0;
  logic [L-1:0] irq_o;
  logic msg_req_o;
  logic [31:0] msg_addr_o, msg_data_o;
  logic [N-1:0] sts_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [31:0] addr; logic [31:0] data; string tag; } msg_t;
  msg_t exp_q[$];

  always #5 clk = ~clk;

  tmr_irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .fire_i(fire_i), .tmr_en_i(tmr_en_i),
    .lvl_type_i(lvl_type_i), .msg_en_i(msg_en_i), .route_i(route_i),
    .msg_word_i(msg_word_i), .glb_en_i(glb_en_i), .legacy_i(legacy_i),
    .rtc_irq_i(rtc_irq_i), .sts_wr_i(sts_wr_i), .sts_wdata_i(sts_wdata_i),
    .irq_o(irq_o), .msg_req_o(msg_req_o), .msg_addr_o(msg_addr_o),
    .msg_data_o(msg_data_o), .sts_o(sts_o)
  );

  task automatic ceq(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic fire(input logic [N-1:0] m);
    fire_i = m;
    step();
    fire_i = '0;
  endtask

  task automatic clr_all();
    sts_wr_i = 1'b1; sts_wdata_i = '1;
    step();
    sts_wr_i = 1'b0; sts_wdata_i = '0;
  endtask

  task automatic push_msg(input int ch, input string tag);
    msg_t m;
    m.addr = msg_word_i[ch*64+32 +: 32];
    m.data = msg_word_i[ch*64 +: 32];
    m.tag  = tag;
    exp_q.push_back(m);
  endtask

  always @(negedge clk) begin
    if (rst_n && msg_req_o) begin
      if (exp_q.size() == 0) begin
        ceq("R6 unexpected message", {msg_addr_o, msg_data_o}, 64'h0);
      end else begin
        msg_t m;
        m = exp_q.pop_front();
        ceq(m.tag, {msg_addr_o, msg_data_o}, {m.addr, m.data});
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    route_i[0*5 +: 5] = 5'd3;
    route_i[1*5 +: 5] = 5'd5;
    route_i[2*5 +: 5] = 5'd12;
    route_i[3*5 +: 5] = 5'd20;
    msg_word_i[2*64 +: 64] = 64'hB000_0020_0000_5678;
    msg_word_i[3*64 +: 64] = 64'hA000_0030_0000_1234;
    repeat (3) step();
    // R1
    ceq("R1 status after reset", sts_o, 0);
    ceq("R1 lines after reset", irq_o, 0);
    ceq("R1 message idle after reset", msg_req_o, 0);
    rst_n = 1'b1;
    glb_en_i = 1'b1; tmr_en_i = '1; lvl_type_i = 4'b0101;
    step();

    // R2 level event on channel 0 (route 3)
    fire(4'b0001);
    ceq("R2 status set", sts_o, 4'b0001);
    ceq("R2 line 3 high", irq_o, 24'h8);
    step(); step();
    ceq("R2 line 3 held", irq_o[3], 1);

    // R4 write of 0 keeps, write of 1 clears
    sts_wr_i = 1'b1; sts_wdata_i = 4'b0000; step(); sts_wr_i = 1'b0;
    ceq("R4 write 0 keeps status", sts_o, 4'b0001);
    sts_wr_i = 1'b1; sts_wdata_i = 4'b0001; step(); sts_wr_i = 1'b0; sts_wdata_i = '0;
    ceq("R4 write 1 clears status", sts_o, 0);
    ceq("R4 line 3 dropped", irq_o[3], 0);

    // R3 edge event on channel 1 (route 5)
    fire(4'b0010);
    ceq("R3 edge leaves status clear", sts_o[1], 0);
    ceq("R3 pulse on line 5", irq_o, 24'h20);
    step();
    ceq("R3 pulse lasts one cycle", irq_o[5], 0);
    lvl_type_i[1] = 1'b1;
    fire(4'b0010);
    ceq("R3 setup level status ch1", sts_o[1], 1);
    lvl_type_i[1] = 1'b0;
    fire(4'b0010);
    ceq("R3 edge clears set status", sts_o[1], 0);
    step();

    // R5 disabled channel / global
    fire(4'b0100);
    ceq("R5 setup ch2 line 12", irq_o[12], 1);
    tmr_en_i[2] = 1'b0;
    fire(4'b0100);
    ceq("R5 disabled channel clears status", sts_o[2], 0);
    ceq("R5 disabled channel line low", irq_o[12], 0);
    tmr_en_i[2] = 1'b1;
    fire(4'b0001);
    glb_en_i = 1'b0;
    fire(4'b0001);
    ceq("R5 global off clears status", sts_o[0], 0);
    ceq("R5 global off line low", irq_o[3], 0);
    glb_en_i = 1'b1;
    step();

    // R6 single message from channel 3
    msg_en_i[3] = 1'b1;
    step();
    push_msg(3, "R6 message address/data ch3");
    fire(4'b1000);
    ceq("R6 routed line untouched", irq_o[20], 0);
    ceq("R6 status untouched", sts_o[3], 0);
    step(); step();

    // R10 simultaneous messages, lowest first
    msg_en_i[2] = 1'b1;
    step();
    push_msg(2, "R10 first message ch2");
    push_msg(3, "R10 second message ch3");
    fire(4'b1100);
    repeat (3) step();
    ceq("R10 all messages delivered", exp_q.size(), 0);
    msg_en_i = '0;
    step();

    // R7 enabling message withdraws level interrupt
    fire(4'b0001);
    ceq("R7 setup status ch0", sts_o[0], 1);
    msg_en_i[0] = 1'b1;
    step();
    ceq("R7 status withdrawn", sts_o[0], 0);
    ceq("R7 line withdrawn", irq_o[3], 0);
    msg_en_i[0] = 1'b0;
    step();
    ceq("R7 line stays low after disable", irq_o[3], 0);

    // R8 compatibility routing
    legacy_i = 1'b1; lvl_type_i = 4'b0111;
    fire(4'b0111);
    ceq("R8 lines in compatibility mode", irq_o, 24'h001101);
    clr_all();
    legacy_i = 1'b0;
    step();

    // R9 real-time-clock pass-through
    rtc_irq_i = 1'b1; step();
    ceq("R9 rtc drives line 8", irq_o[8], 1);
    legacy_i = 1'b1; step();
    ceq("R9 compatibility mode lowers line 8", irq_o[8], 0);
    legacy_i = 1'b0; step();
    ceq("R9 leaving mode restores line 8", irq_o[8], 1);
    rtc_irq_i = 1'b0; step();

    // R11 event beats status clear in the same cycle
    lvl_type_i = 4'b0101;
    fire(4'b0001);
    fire_i = 4'b0001; sts_wr_i = 1'b1; sts_wdata_i = 4'b0001;
    step();
    fire_i = '0; sts_wr_i = 1'b0; sts_wdata_i = '0;
    ceq("R11 event wins over clear", sts_o[0], 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule